// File: doc/BRIEF.md
# One-bit Oversampled Stream to PCM Decimator

This block takes a single-bit oversampled stream from a sigma-delta modulator and turns it into signed multi-bit PCM words, one channel per instance. The stream bit is sampled on every clock where the stream enable is high. That enable runs at 128 times the wanted output sample rate, so one PCM word comes out for every 128 accepted stream bits. Stereo use places two instances side by side.

The conversion has two stages. The first is a cubic comb-integrator (sinc-cubed) filter that divides the rate by 16. The second is a chain of three half-band FIR filters, and each one divides the rate by 2. The first two half-band filters use a short 7-tap coefficient set. The last one, which sets the final transition band, uses an 11-tap set. All arithmetic stays at full precision until the last step, which rounds and clips the result to a 20-bit output word.

Top module: `bsdec_top`

## Requirements
- R1: The stream bit is read as +1 when it is 1 and as -1 when it is 0. A steady 1010... pattern therefore settles to an output of exactly 0.
- R2: The first stage sums the most recent 46 accepted values with the weights of (1 + z^-1 + ... + z^-15)^3. It produces one result on the 16th, 32nd, 48th, ... accepted bit after reset, and values from before reset count as 0.
- R3: Each half-band stage computes y[j] = sum over k of h[k]·u[2j+1-k]. It produces a result on every second input it receives. The coefficients are h = (-1, 0, 9, 16, 9, 0, -1) for stages one and two and h = (3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3) for stage three. Inputs from before reset count as 0.
- R4: The full-precision chain result S has a DC gain of 2^31 for a ±1 input. out_data is floor((S + 2^11) / 2^12), clipped to the signed 20-bit range [-524288, 524287].
- R5: A long run of all ones gives out_data = 524287, because it is clipped. A long run of all zeros gives exactly -524288.
- R6: out_valid is high for exactly one clock per 128 accepted bits. The n-th pulse comes no earlier than the 128·n-th accepted bit and at most a few clocks after it.
- R7: When in_en is low, in_bit has no effect on any later output.
- R8: While rst is high (synchronous, active high), out_valid is 0 and out_data is 0. After reset, all filter history starts again from zero.
- R9: out_data holds its value between out_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Stream enable; the bit is accepted on clocks where this is high |
| in_bit | input | 1 | One-bit oversampled stream value |
| out_valid | output | 1 | One-clock strobe marking a new PCM word |
| out_data | output | OUT_W (20) | Signed PCM word |

## Verification
The filter registers have long memories, so a wrong integrator, comb delay or tap value does not stay hidden. It changes every output word for about nine output samples after the input that hit it, and a modular error in the integrators changes the words for good. The bench therefore compares every PCM word against a direct convolution model, rather than checking only a few steady-state values. A wrong decimation phase or enable-gating error shows up within one 128-bit frame, either as a mismatched word or as a strobe count that no longer equals the number of accepted bits divided by 128.

// File: rtl/bsdec_pkg.sv
package bsdec_pkg;

    localparam int SINC_ORDER = 3;
    localparam int HB_SHORT   = 7;
    localparam int HB_LONG    = 11;
    localparam int HB_COUNT   = 3;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } hb_phase_e;

    // Half-band taps; every other tap is zero except the centre.
    function automatic int hb_coef(input int ntaps, input int k);
        int c;
        c = 0;
        if (ntaps == HB_LONG) begin
            case (k)
                0, 10:   c = 3;
                2, 8:    c = -25;
                4, 6:    c = 150;
                5:       c = 256;
                default: c = 0;
            endcase
        end else begin
            case (k)
                0, 6:    c = -1;
                2, 4:    c = 9;
                3:       c = 16;
                default: c = 0;
            endcase
        end
        return c;
    endfunction

    // Bits of growth needed to hold the worst-case absolute tap sum.
    function automatic int hb_growth(input int ntaps);
        int s;
        s = 0;
        for (int k = 0; k < ntaps; k++) begin
            s += (hb_coef(ntaps, k) < 0) ? -hb_coef(ntaps, k) : hb_coef(ntaps, k);
        end
        return $clog2(s);
    endfunction

    // log2 of the DC gain of a half-band set (tap sum is a power of two).
    function automatic int hb_gain_l2(input int ntaps);
        int s;
        s = 0;
        for (int k = 0; k < ntaps; k++) begin
            s += hb_coef(ntaps, k);
        end
        return $clog2(s);
    endfunction

    // Tap count for half-band stage s (0-based): the last stage is the long one.
    function automatic int hb_stage_taps(input int s);
        return (s == HB_COUNT - 1) ? HB_LONG : HB_SHORT;
    endfunction

endpackage

// File: rtl/bsdec_cic.sv
module bsdec_cic
    import bsdec_pkg::*;
#(
    parameter int R = 16,
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_en,
    input  logic                in_bit,
    output logic                out_vld,
    output logic signed [W-1:0] out_smp
);
    localparam int CW = $clog2(R);

    logic [CW-1:0]       phase_cnt;
    logic signed [W-1:0] integ   [SINC_ORDER];
    logic signed [W-1:0] integ_n [SINC_ORDER];
    logic signed [W-1:0] comb_d  [SINC_ORDER];
    logic signed [W-1:0] diff    [SINC_ORDER+1];
    logic signed [W-1:0] step_v;

    always_comb begin
        step_v     = in_bit ? W'(1) : W'(-1);
        integ_n[0] = integ[0] + step_v;
        for (int s = 1; s < SINC_ORDER; s++) begin
            integ_n[s] = integ[s] + integ_n[s-1];
        end
        diff[0] = integ_n[SINC_ORDER-1];
        for (int s = 0; s < SINC_ORDER; s++) begin
            diff[s+1] = diff[s] - comb_d[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cnt <= '0;
            out_vld   <= 1'b0;
            out_smp   <= '0;
            for (int s = 0; s < SINC_ORDER; s++) begin
                integ[s]  <= '0;
                comb_d[s] <= '0;
            end
        end else begin
            out_vld <= 1'b0;
            if (in_en) begin
                integ     <= integ_n;
                phase_cnt <= phase_cnt + 1'b1;
                if (phase_cnt == CW'(R - 1)) begin
                    for (int s = 0; s < SINC_ORDER; s++) begin
                        comb_d[s] <= diff[s];
                    end
                    out_smp <= diff[SINC_ORDER];
                    out_vld <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bsdec_halfband.sv
module bsdec_halfband
    import bsdec_pkg::*;
#(
    parameter int IW    = 14,
    parameter int NTAPS = HB_SHORT,
    parameter int OW    = IW + hb_growth(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] in_smp,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_smp
);
    logic signed [IW-1:0] line [NTAPS-1];
    logic signed [OW-1:0] win  [NTAPS];
    logic signed [OW-1:0] acc;
    hb_phase_e            ph;

    always_comb begin
        win[0] = OW'(in_smp);
        for (int k = 1; k < NTAPS; k++) begin
            win[k] = OW'(line[k-1]);
        end
        acc = '0;
        for (int k = 0; k < NTAPS; k++) begin
            if (hb_coef(NTAPS, k) != 0) begin
                acc = acc + win[k] * OW'(hb_coef(NTAPS, k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_EVEN;
            out_vld <= 1'b0;
            out_smp <= '0;
            for (int k = 0; k < NTAPS - 1; k++) begin
                line[k] <= '0;
            end
        end else begin
            out_vld <= 1'b0;
            if (in_vld) begin
                line[0] <= in_smp;
                for (int k = 1; k < NTAPS - 1; k++) begin
                    line[k] <= line[k-1];
                end
                ph <= (ph == PH_EVEN) ? PH_ODD : PH_EVEN;
                if (ph == PH_ODD) begin
                    out_smp <= acc;
                    out_vld <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bsdec_outfmt.sv
module bsdec_outfmt #(
    parameter int IW    = 36,
    parameter int SHIFT = 12,
    parameter int OW    = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] in_smp,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_smp
);
    localparam int RW = IW + 1;
    localparam int QW = RW - SHIFT;
    localparam logic signed [QW-1:0] QMAX = QW'((2 ** (OW - 1)) - 1);
    localparam logic signed [QW-1:0] QMIN = QW'(-(2 ** (OW - 1)));

    logic signed [RW-1:0] rnd;
    logic signed [QW-1:0] quo;
    logic signed [OW-1:0] clip;

    always_comb begin
        rnd = RW'(in_smp) + (RW'(1) <<< (SHIFT - 1));
        quo = QW'(rnd >>> SHIFT);
        if (quo > QMAX) begin
            clip = {1'b0, {(OW-1){1'b1}}};
        end else if (quo < QMIN) begin
            clip = {1'b1, {(OW-1){1'b0}}};
        end else begin
            clip = OW'(quo);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_smp <= clip;
            end
        end
    end

endmodule

// File: rtl/bsdec_top.sv
module bsdec_top
    import bsdec_pkg::*;
#(
    parameter int DEC_SINC = 16,
    parameter int OUT_W    = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_en,
    input  logic                    in_bit,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int SINC_W    = SINC_ORDER * $clog2(DEC_SINC) + 2;
    localparam int HB1_W     = SINC_W + hb_growth(hb_stage_taps(0));
    localparam int HB2_W     = HB1_W + hb_growth(hb_stage_taps(1));
    localparam int HB3_W     = HB2_W + hb_growth(hb_stage_taps(2));
    localparam int GAIN_L2   = SINC_ORDER * $clog2(DEC_SINC)
                             + hb_gain_l2(hb_stage_taps(0))
                             + hb_gain_l2(hb_stage_taps(1))
                             + hb_gain_l2(hb_stage_taps(2));
    localparam int OUT_SHIFT = GAIN_L2 - (OUT_W - 1);

    logic                     sinc_vld, hb1_vld, hb2_vld, hb3_vld;
    logic signed [SINC_W-1:0] sinc_smp;
    logic signed [HB1_W-1:0]  hb1_smp;
    logic signed [HB2_W-1:0]  hb2_smp;
    logic signed [HB3_W-1:0]  hb3_smp;

    bsdec_cic #(.R(DEC_SINC), .W(SINC_W)) u_sinc (
        .clk(clk), .rst(rst), .in_en(in_en), .in_bit(in_bit),
        .out_vld(sinc_vld), .out_smp(sinc_smp)
    );

    bsdec_halfband #(.IW(SINC_W), .NTAPS(hb_stage_taps(0)), .OW(HB1_W)) u_hb1 (
        .clk(clk), .rst(rst), .in_vld(sinc_vld), .in_smp(sinc_smp),
        .out_vld(hb1_vld), .out_smp(hb1_smp)
    );

    bsdec_halfband #(.IW(HB1_W), .NTAPS(hb_stage_taps(1)), .OW(HB2_W)) u_hb2 (
        .clk(clk), .rst(rst), .in_vld(hb1_vld), .in_smp(hb1_smp),
        .out_vld(hb2_vld), .out_smp(hb2_smp)
    );

    bsdec_halfband #(.IW(HB2_W), .NTAPS(hb_stage_taps(2)), .OW(HB3_W)) u_hb3 (
        .clk(clk), .rst(rst), .in_vld(hb2_vld), .in_smp(hb2_smp),
        .out_vld(hb3_vld), .out_smp(hb3_smp)
    );

    bsdec_outfmt #(.IW(HB3_W), .SHIFT(OUT_SHIFT), .OW(OUT_W)) u_fmt (
        .clk(clk), .rst(rst), .in_vld(hb3_vld), .in_smp(hb3_smp),
        .out_vld(out_valid), .out_smp(out_data)
    );

endmodule

// File: rtl/bsdec_chk.sv
module bsdec_chk #(
    parameter int OUT_W  = 20,
    parameter int FRAME  = 128,
    parameter int MAXLAT = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_en,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);
    logic [31:0]             en_cnt;
    logic [31:0]             v_cnt;
    logic signed [OUT_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_cnt <= '0;
            v_cnt  <= '0;
            held   <= '0;
        end else begin
            if (in_en)     en_cnt <= en_cnt + 32'd1;
            if (out_valid) begin
                v_cnt <= v_cnt + 32'd1;
                held  <= out_data;
            end
        end
    end

    // R6
    strobe_early_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (en_cnt >= 32'(FRAME) * (v_cnt + 32'd1)));

    // R6
    strobe_late_chk: assert property (@(posedge clk) disable iff (rst)
        en_cnt <= 32'(FRAME) * (v_cnt + 32'd1) + 32'(MAXLAT));

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == held));

endmodule

bind bsdec_top bsdec_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .in_en(in_en), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/bsdec_top_tb.sv
module bsdec_top_tb;
    localparam int OUT_W = 20;
    localparam int FRAME = 128;
    localparam int MAXX  = 8192;
    localparam int MAXO  = MAXX / FRAME;
    localparam int H7 [7]   = '{-1, 0, 9, 16, 9, 0, -1};
    localparam int H11 [11] = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};

    typedef struct packed {
        int code;      // 0 ones, 1 zeros, 2 alternate, 3 pseudo-random, 4 square, 5 density 3/4
        int frames;
        int gap;       // disabled cycles after each accepted bit
        int chk;       // 1: check last word of this vector
        int exp_last;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{0, 10, 0, 1, 524287},
        '{1, 10, 0, 1, -524288},
        '{2, 10, 0, 1, 0},
        '{3,  6, 0, 0, 0},
        '{4,  6, 0, 0, 0},
        '{5,  6, 0, 0, 0},
        '{0, 10, 2, 1, 524287}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_en = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int xs [MAXX];
    int nx = 0;
    int got [MAXO];
    int ngot = 0;
    int held = 0;
    int hold_bad = 0;
    int ck_idx [NVEC];
    int sinc_c [46];
    longint cic [MAXX/16];
    longint hb1 [MAXX/32];
    longint hb2 [MAXX/64];
    longint hb3 [MAXO];
    int expv [MAXO];
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;

    bsdec_top #(.OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_bit(in_bit),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // Output monitor, sampled 2 ns after the active edge.
    always @(posedge clk) begin
        #2;
        if (rst) begin
            held = 0;
        end else if (out_valid) begin
            if (ngot < MAXO) got[ngot] = int'(out_data);
            ngot++;
            held = int'(out_data);
        end else if (int'(out_data) != held) begin
            hold_bad++;
        end
    end

    task automatic check(input string req, input longint act, input longint exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic step(input bit en, input bit b);
        @(negedge clk);
        in_en  = en;
        in_bit = b;
        if (en) begin
            xs[nx] = b ? 1 : -1;
            nx++;
        end
    endtask

    task automatic build_sinc();
        int c1 [31];
        for (int i = 0; i < 31; i++) c1[i] = 0;
        for (int i = 0; i < 46; i++) sinc_c[i] = 0;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) c1[a+b] += 1;
        for (int a = 0; a < 31; a++)
            for (int b = 0; b < 16; b++) sinc_c[a+b] += c1[a];
    endtask

    task automatic compute_model();
        longint acc;
        longint r;
        for (int m = 0; m < nx / 16; m++) begin
            acc = 0;
            for (int k = 0; k < 46; k++)
                if (16*m + 15 - k >= 0) acc += longint'(sinc_c[k]) * xs[16*m + 15 - k];
            cic[m] = acc;
        end
        for (int j = 0; j < nx / 32; j++) begin
            acc = 0;
            for (int k = 0; k < 7; k++)
                if (2*j + 1 - k >= 0) acc += H7[k] * cic[2*j + 1 - k];
            hb1[j] = acc;
        end
        for (int j = 0; j < nx / 64; j++) begin
            acc = 0;
            for (int k = 0; k < 7; k++)
                if (2*j + 1 - k >= 0) acc += H7[k] * hb1[2*j + 1 - k];
            hb2[j] = acc;
        end
        for (int j = 0; j < nx / 128; j++) begin
            acc = 0;
            for (int k = 0; k < 11; k++)
                if (2*j + 1 - k >= 0) acc += H11[k] * hb2[2*j + 1 - k];
            hb3[j] = acc;
            r = (acc + 2048) >>> 12;
            if (r > 524287) r = 524287;
            if (r < -524288) r = -524288;
            expv[j] = int'(r);
        end
    endtask

    task automatic compare_all(input string tag);
        compute_model();
        check({tag, " R6 strobe count"}, ngot, nx / FRAME);
        for (int i = 0; i < nx / FRAME && i < ngot; i++)
            check({tag, " R2/R3/R4 word"}, got[i], expv[i]);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        build_sinc();
        repeat (4) @(negedge clk);
        // R8: outputs cleared during reset
        check("R8 reset valid", out_valid, 0);
        check("R8 reset data", out_data, 0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table walk, one continuous session
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < VECS[v].frames * FRAME; i++) begin
                bit b;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (VECS[v].code)
                    0:       b = 1'b1;
                    1:       b = 1'b0;
                    2:       b = i[0];
                    3:       b = lfsr[0];
                    4:       b = i[8];
                    default: b = (i % 4) != 3;
                endcase
                step(1'b1, b);
                // R7: junk on the bit line while disabled
                for (int g = 0; g < VECS[v].gap; g++) step(1'b0, ~b);
            end
            ck_idx[v] = nx / FRAME - 1;
        end
        repeat (12) step(1'b0, 1'b0);
        compare_all("main");

        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].chk != 0) begin
                if (VECS[v].gap > 0)
                    check("R7 gated ones word", got[ck_idx[v]], VECS[v].exp_last);
                else if (VECS[v].code == 2)
                    check("R1 alternating word", got[ck_idx[v]], VECS[v].exp_last);
                else
                    check("R5 full-scale word", got[ck_idx[v]], VECS[v].exp_last);
            end
        end
        check("R9 hold between strobes", hold_bad, 0);

        // Mid-stream reset: history must restart from zero (R8)
        nx = 0;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b1, lfsr[0]);
        end
        @(negedge clk);
        rst = 1'b1;
        in_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 mid reset valid", out_valid, 0);
        check("R8 mid reset data", out_data, 0);
        nx = 0;
        ngot = 0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5 * FRAME; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b1, lfsr[0]);
        end
        repeat (12) step(1'b0, 1'b0);
        compare_all("after reset R8");
        check("R9 hold after reset", hold_bad, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule